// File: doc/BRIEF.md
# Deferred Store Buffer with Release Flush

This block sits between a processor's store path and the network of a shared-memory node. Local stores are not forwarded when they occur. They are held in a small tagged buffer, one entry per block address, and a later store to the same block replaces the held data in place. Nothing leaves the node until the processor issues a release. The release then sends every held block out as a single burst and places the release access itself (for example, a ready flag) at the end of that burst.

During the flush the processor side is stalled. The flush finishes when the network acknowledges the burst. The block then raises a one-cycle release-done pulse and clears the whole buffer in the same cycle. Release latency therefore grows with the number of blocks held. A store to a new block while all entries are occupied waits until the next release has emptied the buffer.

Top module: `deferred_store_buffer`

## Requirements
- R1: After reset `pkt_valid` and `rel_done` are 0, and `st_ready` and `rel_ready` are 1.
- R2: While no release is in progress, `pkt_valid` stays 0, so no store is forwarded before a release.
- R3: A store to an address already held overwrites that entry's data. At the next release that address is sent exactly once, carrying the latest data.
- R4: A store to a new address takes the lowest free entry. The flush sends entries in ascending entry order, which matches the order in which each address was first stored since the previous release.
- R5: When all SLOTS entries are held, a store to an address not held sees `st_ready`=0. A store to a held address is still accepted.
- R6: A release is accepted on `rel_valid` while `rel_ready`=1. From the next cycle until `rel_done`, both `st_ready` and `rel_ready` are 0.
- R7: Data packets carry `pkt_rel`=0. The release packet carries `pkt_rel`=1 with the captured `rel_addr`/`rel_data` and follows every data packet of its burst. No further packet follows it before the next release.
- R8: While `pkt_valid`=1 and `pkt_ready`=0, the packet fields hold steady into the next cycle.
- R9: `rel_done` is a one-cycle pulse. It rises in the cycle after `net_ack` is seen once the release packet has been taken. `net_ack` has no effect at any other time.
- R10: When `rel_done` is raised, all entries are cleared. A following release with no new stores sends only the release packet.
- R11: A store accepted in the same cycle as a release is part of that release's burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W | Store block address |
| st_data | input | DATA_W | Store data |
| st_ready | output | 1 | Store accepted this cycle when high with `st_valid` |
| rel_valid | input | 1 | Release request |
| rel_addr | input | ADDR_W | Address of the release access |
| rel_data | input | DATA_W | Data of the release access |
| rel_ready | output | 1 | Release accepted this cycle when high with `rel_valid` |
| pkt_valid | output | 1 | Propagation packet present |
| pkt_ready | input | 1 | Network takes the packet |
| pkt_addr | output | ADDR_W | Packet block address |
| pkt_data | output | DATA_W | Packet data |
| pkt_rel | output | 1 | Packet is the release access |
| net_ack | input | 1 | Network acknowledges the burst |
| rel_done | output | 1 | Release complete pulse |

## Verification
The store path and the release path can act in the same cycle. A store and a release are both presented on one edge while the block is idle. The store must be taken and must appear in the burst that this release starts. The bench provokes this on purpose, with both a new address and an address already held, and judges it against its own model of first-store order and latest data. A second overlap is a network acknowledge that arrives while the flush is still draining. The bench sends one and checks that `rel_done` does not rise until the real acknowledge.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
    typedef enum logic [1:0] {
        FS_IDLE,
        FS_DRAIN,
        FS_RELEASE,
        FS_WAIT
    } flush_state_e;
endpackage

// File: rtl/dsb_lookup.sv
module dsb_lookup #(
    parameter int ADDR_W = 16,
    parameter int SLOTS  = 16,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [SLOTS-1:0]             vld,
    input  logic [SLOTS-1:0][ADDR_W-1:0] tags,
    input  logic [ADDR_W-1:0]            addr,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx,
    output logic                         free_ok,
    output logic [IDX_W-1:0]             free_idx
);
    logic [SLOTS-1:0] match;

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign match[g] = vld[g] && (tags[g] == addr);
    end

    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!vld[i]) begin
                free_ok  = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dsb_scan.sv
module dsb_scan #(
    parameter int SLOTS  = 16,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int PTR_W = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS-1:0] vld,
    input  logic [PTR_W-1:0] ptr,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    logic [SLOTS-1:0] elig;

    for (genvar g = 0; g < SLOTS; g++) begin : g_elig
        assign elig[g] = vld[g] && (PTR_W'(g) >= ptr);
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/deferred_store_buffer.sv
module deferred_store_buffer
    import dsb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SLOTS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    output logic              st_ready,
    input  logic              rel_valid,
    input  logic [ADDR_W-1:0] rel_addr,
    input  logic [DATA_W-1:0] rel_data,
    output logic              rel_ready,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic [ADDR_W-1:0] pkt_addr,
    output logic [DATA_W-1:0] pkt_data,
    output logic              pkt_rel,
    input  logic              net_ack,
    output logic              rel_done
);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int PTR_W = $clog2(SLOTS + 1);

    typedef struct packed {
        flush_state_e                 st;
        logic [PTR_W-1:0]             ptr;
        logic [SLOTS-1:0]             vld;
        logic [SLOTS-1:0][ADDR_W-1:0] tag;
        logic [SLOTS-1:0][DATA_W-1:0] dat;
        logic [ADDR_W-1:0]            raddr;
        logic [DATA_W-1:0]            rdata;
        logic                         done;
    } regs_t;

    regs_t r_d, r_q;

    logic             hit, free_ok, scan_found;
    logic [IDX_W-1:0] hit_idx, free_idx, scan_idx;

    dsb_lookup #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_lookup (
        .vld      (r_q.vld),
        .tags     (r_q.tag),
        .addr     (st_addr),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .free_ok  (free_ok),
        .free_idx (free_idx)
    );

    dsb_scan #(.SLOTS(SLOTS)) u_scan (
        .vld   (r_q.vld),
        .ptr   (r_q.ptr),
        .found (scan_found),
        .idx   (scan_idx)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        st_ready  = (r_q.st == FS_IDLE) && (hit || free_ok);
        rel_ready = (r_q.st == FS_IDLE);
        pkt_valid = 1'b0;
        pkt_rel   = 1'b0;
        pkt_addr  = r_q.tag[scan_idx];
        pkt_data  = r_q.dat[scan_idx];
        unique case (r_q.st)
            FS_IDLE: begin
                if (st_valid && st_ready) begin
                    if (hit) begin
                        r_d.dat[hit_idx] = st_data;
                    end else begin
                        r_d.vld[free_idx] = 1'b1;
                        r_d.tag[free_idx] = st_addr;
                        r_d.dat[free_idx] = st_data;
                    end
                end
                if (rel_valid) begin
                    r_d.st    = FS_DRAIN;
                    r_d.ptr   = '0;
                    r_d.raddr = rel_addr;
                    r_d.rdata = rel_data;
                end
            end
            FS_DRAIN: begin
                pkt_valid = scan_found;
                if (!scan_found) begin
                    r_d.st = FS_RELEASE;
                end else if (pkt_ready) begin
                    r_d.ptr = PTR_W'(scan_idx) + PTR_W'(1);
                end
            end
            FS_RELEASE: begin
                pkt_valid = 1'b1;
                pkt_rel   = 1'b1;
                pkt_addr  = r_q.raddr;
                pkt_data  = r_q.rdata;
                if (pkt_ready) r_d.st = FS_WAIT;
            end
            FS_WAIT: begin
                if (net_ack) begin
                    r_d.vld  = '0;
                    r_d.done = 1'b1;
                    r_d.st   = FS_IDLE;
                end
            end
            default: r_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= FS_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign rel_done = r_q.done;

    // R8
    pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_addr) && $stable(pkt_data) && $stable(pkt_rel));

    // R7
    rel_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && pkt_ready && pkt_rel |=> !pkt_valid);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_done |=> !rel_done);

    // R6
    flush_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_ready |-> !st_ready);

    // R5
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !hit && (&r_q.vld) |-> !st_ready);

    // R10
    done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_done |-> r_q.vld == '0);
endmodule

// File: tb/sim_deferred_store_buffer.sv
module sim_deferred_store_buffer;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          st_ready;
    logic          rel_valid = 1'b0;
    logic [AW-1:0] rel_addr = '0;
    logic [DW-1:0] rel_data = '0;
    logic          rel_ready;
    logic          pkt_valid;
    logic          pkt_ready = 1'b0;
    logic [AW-1:0] pkt_addr;
    logic [DW-1:0] pkt_data;
    logic          pkt_rel;
    logic          net_ack = 1'b0;
    logic          rel_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [AW-1:0] m_addr [NS];
    logic [DW-1:0] m_data [NS];
    int m_cnt = 0;

    always #10 clk = ~clk;

    deferred_store_buffer #(.ADDR_W(AW), .DATA_W(DW), .SLOTS(NS)) u0 (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
        .rel_valid(rel_valid), .rel_addr(rel_addr), .rel_data(rel_data), .rel_ready(rel_ready),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_addr(pkt_addr), .pkt_data(pkt_data),
        .pkt_rel(pkt_rel), .net_ack(net_ack), .rel_done(rel_done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int find_slot(input logic [AW-1:0] a);
        for (int i = 0; i < m_cnt; i++) if (m_addr[i] == a) return i;
        return -1;
    endfunction

    function automatic void model_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int s = find_slot(a);
        if (s >= 0) m_data[s] = d;
        else begin
            m_addr[m_cnt] = a;
            m_data[m_cnt] = d;
            m_cnt++;
        end
    endfunction

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bit miss_full;
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d;
        #1;
        miss_full = (find_slot(a) < 0) && (m_cnt == NS);
        if (miss_full) begin
            chk(st_ready == 1'b0, "R5 full miss stalls", st_ready, 0);
            st_valid = 1'b0;
        end else begin
            chk(st_ready == 1'b1, "R5/R3 store accepted", st_ready, 1);
            @(posedge clk);
            model_store(a, d);
            #1 st_valid = 1'b0;
        end
    endtask

    task automatic do_release(input logic [AW-1:0] ra, input logic [DW-1:0] rd,
                              input bit with_st, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                              input bit spurious);
        int idx = 0;
        int cyc = 0;
        bit got_rel = 1'b0;
        bit hold = 1'b0;
        logic [AW-1:0] h_a;
        logic [DW-1:0] h_d;
        logic h_r;
        bit pr;
        @(negedge clk);
        chk(rel_ready == 1'b1, "R6 release ready when idle", rel_ready, 1);
        chk(pkt_valid == 1'b0, "R2 no packet before release", pkt_valid, 0);
        rel_valid = 1'b1; rel_addr = ra; rel_data = rd;
        if (with_st) begin
            st_valid = 1'b1; st_addr = sa; st_data = sd;
            #1 chk(st_ready == 1'b1, "R11 store beside release accepted", st_ready, 1);
        end
        @(posedge clk);
        if (with_st) model_store(sa, sd);
        #1 rel_valid = 1'b0; st_valid = 1'b0;
        while (!got_rel && cyc < 300) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                chk(st_ready == 1'b0, "R6 stores stalled in flush", st_ready, 0);
                chk(rel_ready == 1'b0, "R6 release not ready in flush", rel_ready, 0);
            end
            if (hold) begin
                chk(pkt_valid && pkt_addr == h_a && pkt_data == h_d && pkt_rel == h_r,
                    "R8 packet held", {pkt_addr, pkt_data[15:0]}, {h_a, h_d[15:0]});
            end
            net_ack = (spurious && cyc == 2);
            pr = ($urandom % 3) != 0;
            pkt_ready = pr;
            hold = 1'b0;
            if (pkt_valid) begin
                if (!pr) begin
                    hold = 1'b1; h_a = pkt_addr; h_d = pkt_data; h_r = pkt_rel;
                end else if (pkt_rel) begin
                    chk(idx == m_cnt, "R7 release packet last", idx, m_cnt);
                    chk(pkt_addr == ra && pkt_data == rd, "R7 release packet fields",
                        {pkt_addr, pkt_data}, {ra, rd});
                    got_rel = 1'b1;
                end else begin
                    chk(idx < m_cnt, "R10/R3 no extra data packet", idx, m_cnt);
                    if (idx < m_cnt)
                        chk(pkt_addr == m_addr[idx] && pkt_data == m_data[idx],
                            "R4/R3 data packet order and value",
                            {pkt_addr, pkt_data}, {m_addr[idx], m_data[idx]});
                    idx++;
                end
            end
        end
        chk(got_rel, "R7 release packet seen", got_rel, 1);
        @(negedge clk);
        pkt_ready = 1'b0; net_ack = 1'b0;
        chk(pkt_valid == 1'b0, "R7 nothing after release packet", pkt_valid, 0);
        chk(rel_done == 1'b0, "R9 no done before ack", rel_done, 0);
        for (int w = 0; w < int'($urandom % 3); w++) @(negedge clk);
        net_ack = 1'b1;
        @(negedge clk);
        net_ack = 1'b0;
        chk(rel_done == 1'b1, "R9 done after ack", rel_done, 1);
        @(negedge clk);
        chk(rel_done == 1'b0, "R9 done one cycle", rel_done, 0);
        chk(st_ready == 1'b1 && rel_ready == 1'b1, "R10 idle again", {st_ready, rel_ready}, 2'b11);
        m_cnt = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(pkt_valid == 1'b0 && rel_done == 1'b0, "R1 outputs low after reset", {pkt_valid, rel_done}, 0);
        chk(st_ready == 1'b1 && rel_ready == 1'b1, "R1 ready after reset", {st_ready, rel_ready}, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);
        chk(st_ready && rel_ready && !pkt_valid, "R1 idle after reset release", {st_ready, rel_ready, pkt_valid}, 3'b110);

        // R10: empty release sends only the release packet
        do_release(16'hF000, 32'h1, 1'b0, '0, '0, 1'b1);

        // R3 R4: data then ready flag in one burst, with an overwrite
        do_store(16'h0040, 32'hAAAA0001);
        do_store(16'h0010, 32'hBBBB0002);
        do_store(16'h0040, 32'hAAAA0003);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(pkt_valid == 1'b0, "R2 held stores stay local", pkt_valid, 0);
        end
        do_release(16'h0FFF, 32'h00000001, 1'b0, '0, '0, 1'b0);

        // R5: fill all entries, then miss stalls and hit is accepted
        for (int k = 0; k < NS; k++) do_store(AW'(16'h0100 + k), DW'(k));
        do_store(16'h0200, 32'hDEAD);
        do_store(16'h0105, 32'h5555);
        do_release(16'h0FFE, 32'h2, 1'b0, '0, '0, 1'b1);
        do_store(16'h0200, 32'hBEEF);
        // R11: store on the same edge as the release, new address then held address
        do_release(16'h0FFD, 32'h3, 1'b1, 16'h0300, 32'h3333, 1'b0);
        do_store(16'h0400, 32'h4444);
        do_release(16'h0FFC, 32'h4, 1'b1, 16'h0400, 32'h4445, 1'b1);

        // random rounds
        for (int r = 0; r < 30; r++) begin
            int n = int'($urandom % 22);
            for (int k = 0; k < n; k++)
                do_store(AW'($urandom % 24), DW'($urandom));
            do_release(AW'(16'h0E00 + r), DW'($urandom), bit'($urandom % 2),
                       AW'($urandom % 24), DW'($urandom), bit'($urandom % 2));
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule